// File: doc/BRIEF.md
# Interpolating Sine Table Reader

This block turns a phase word into a sine sample. It uses a full-period sine table that is shorter than the output resolution needs, and it makes up the difference by linear interpolation. The phase word has two parts. The upper part selects table entry `i`. The lower part gives a fractional position `k` on the way from entry `i` to entry `i+1`, in steps of 1/N, where N is a power of two.

The block reads both neighbouring entries in the same cycle. It forms a weighted sum in an accumulator wider than the sample word, then rounds and shifts the sum back to the sample width. Because N is a power of two, that shift replaces a divider.

The datapath is a three-stage pipeline, so a new phase word can be accepted on every clock and a new sample leaves on every clock. When the index reaches the last table entry, the upper neighbour wraps back to entry 0, so the waveform stays continuous across the period boundary.

Top module: `sine_lerp_interp`

## Requirements
- R1: While `rst_n` is low at a rising edge, and after that edge, `out_valid` is 0 and `out_sample` is 0.
- R2: A phase word accepted at a rising edge, with `in_valid` high, produces its result with `out_valid` high after the second rising edge that follows the capture edge.
- R3: When `k` is 0, `out_sample` equals table entry `i` exactly.
- R4: `out_sample` equals floor(((N-k)*s[i] + k*s[i+1] + N/2) / N), with signed samples and N = 2^FRAC_W. This is rounding half up, and the result always fits the sample width.
- R5: For `i` = 2^IDX_W - 1, the upper neighbour `s[i+1]` is entry 0.
- R6: `in_phase[IDX_W+FRAC_W-1:FRAC_W]` is the index `i`, and `in_phase[FRAC_W-1:0]` is `k`.
- R7: Table entry `s[j]` is A*sin(2*pi*j/2^IDX_W) rounded half away from zero, with A = 2^(DATA_W-1) - 1.
- R8: Phase words given on consecutive cycles produce results on consecutive cycles, one per accepted word, in input order, with no gap.
- R9: A cycle with `in_valid` low produces no output. `out_sample` holds its last value, and `in_phase` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Phase word on `in_phase` is to be processed |
| in_phase | input | IDX_W+FRAC_W | Table index (upper bits) and fractional position (lower bits) |
| out_valid | output | 1 | `out_sample` carries a new result |
| out_sample | output | DATA_W | Interpolated signed sample |

## Verification
The wrap-around to entry 0 and the half-LSB rounding meet in the same cycle when the index is the last entry and `k` is nonzero. At that point the upper neighbour comes from the other end of the table, and the weighted sum can land exactly on a rounding tie. The bench drives every nonzero `k` at the last index, back-to-back and mixed with ordinary indices. A scoreboard compares each result with the rounded formula, using entry 0 as the upper neighbour. Idle gaps that carry changing phase words confirm that the output holds still.

// File: rtl/sine_lerp_pkg.sv
// Package: shared helpers for the interpolating sine reader.
// Assumes: callers pass a table length that is a power of two and a
// sample width of at most 31 bits.
package sine_lerp_pkg;

    // Rounded sine value for table slot j (half away from zero).
    function automatic int sine_entry(input int j, input int len, input int dw);
        real amp;
        real ang;
        real v;
        amp = real'((1 << (dw - 1)) - 1);
        ang = 6.283185307179586 * real'(j) / real'(len);
        v   = amp * $sin(ang);
        if (v >= 0.0)
            return $rtoi(v + 0.5);
        else
            return -$rtoi(0.5 - v);
    endfunction

endpackage

// File: rtl/sine_lerp_table.sv
// Module: stage 1, dual-neighbour table read.
// Holds a constant full-period sine table and reads entries idx and idx+1
// in the same cycle. The +1 wraps naturally because the table length is
// 2^IDX_W. All registers load only on in_valid, so they hold when idle.
// Assumes: synchronous active-low reset.
module sine_lerp_table
    import sine_lerp_pkg::*;
#(
    parameter int IDX_W  = 10,
    parameter int FRAC_W = 3,
    parameter int DATA_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [IDX_W-1:0]         idx,
    input  logic [FRAC_W-1:0]        frac,
    output logic                     rd_valid,
    output logic signed [DATA_W-1:0] samp_lo,
    output logic signed [DATA_W-1:0] samp_hi,
    output logic [FRAC_W-1:0]        frac_d
);
    localparam int LEN = 1 << IDX_W;

    logic signed [DATA_W-1:0] rom [LEN];
    logic [IDX_W-1:0]         idx_nxt;

    // Constant table contents, one generated slot per entry.
    for (genvar j = 0; j < LEN; j++) begin : g_rom
        assign rom[j] = DATA_W'(sine_entry(j, LEN, DATA_W));
    end

    // Neighbour index, wrapping modulo the table length.
    assign idx_nxt = idx + 1'b1;

    // Read both neighbours and carry the fraction forward.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            samp_lo  <= '0;
            samp_hi  <= '0;
            frac_d   <= '0;
        end else begin
            rd_valid <= in_valid;
            if (in_valid) begin
                samp_lo <= rom[idx];
                samp_hi <= rom[idx_nxt];
                frac_d  <= frac;
            end
        end
    end

    // R2
    r2_read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> rd_valid);

    // R5
    r5_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (idx == {IDX_W{1'b1}})) |=> (samp_hi == rom[0]));

endmodule

// File: rtl/sine_lerp_weight.sv
// Module: stage 2, weighting multiplies.
// Computes (N-k)*s_lo and k*s_hi at accumulator width. The samples are
// sign-extended first, and the weights are zero-extended because they are
// non-negative.
// Assumes: ACC_W = DATA_W + FRAC_W + 1, so that neither product overflows.
module sine_lerp_weight #(
    parameter int FRAC_W = 3,
    parameter int DATA_W = 12,
    parameter int ACC_W  = DATA_W + FRAC_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     v_in,
    input  logic signed [DATA_W-1:0] samp_lo,
    input  logic signed [DATA_W-1:0] samp_hi,
    input  logic [FRAC_W-1:0]        frac,
    output logic                     v_out,
    output logic signed [ACC_W-1:0]  prod_lo,
    output logic signed [ACC_W-1:0]  prod_hi
);
    localparam int N = 1 << FRAC_W;

    logic [FRAC_W:0]         w_lo;
    logic signed [ACC_W-1:0] w_lo_x;
    logic signed [ACC_W-1:0] w_hi_x;
    logic signed [ACC_W-1:0] s_lo_x;
    logic signed [ACC_W-1:0] s_hi_x;

    // Weights and operand extension to accumulator width.
    always_comb begin
        w_lo   = (FRAC_W + 1)'(N) - {1'b0, frac};
        w_lo_x = {{(ACC_W - FRAC_W - 1){1'b0}}, w_lo};
        w_hi_x = {{(ACC_W - FRAC_W){1'b0}}, frac};
        s_lo_x = {{(ACC_W - DATA_W){samp_lo[DATA_W-1]}}, samp_lo};
        s_hi_x = {{(ACC_W - DATA_W){samp_hi[DATA_W-1]}}, samp_hi};
    end

    // Register both products when a valid word passes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_out   <= 1'b0;
            prod_lo <= '0;
            prod_hi <= '0;
        end else begin
            v_out <= v_in;
            if (v_in) begin
                prod_lo <= w_lo_x * s_lo_x;
                prod_hi <= w_hi_x * s_hi_x;
            end
        end
    end

    // R3
    r3_zero_frac_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_in && (frac == '0)) |=> (prod_hi == '0));

    // R2
    r2_mult_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_in |=> v_out);

endmodule

// File: rtl/sine_lerp_sum.sv
// Module: stage 3, add, round and truncate.
// Adds the two products and half an output LSB (N/2), then shifts right
// arithmetically by FRAC_W and keeps the low DATA_W bits. The output
// register loads only on a valid word, so it holds when idle.
// Assumes: the products come from a convex weighting of in-range samples.
module sine_lerp_sum #(
    parameter int FRAC_W = 3,
    parameter int DATA_W = 12,
    parameter int ACC_W  = DATA_W + FRAC_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     v_in,
    input  logic signed [ACC_W-1:0]  prod_lo,
    input  logic signed [ACC_W-1:0]  prod_hi,
    output logic                     v_out,
    output logic signed [DATA_W-1:0] sample
);
    localparam int                N      = 1 << FRAC_W;
    localparam logic [ACC_W-1:0] HALF_V = ACC_W'(N / 2);

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] shifted;

    // Weighted sum with the rounding offset, then power-of-two normalise.
    always_comb begin
        acc     = prod_lo + prod_hi + $signed(HALF_V);
        shifted = acc >>> FRAC_W;
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_out  <= 1'b0;
            sample <= '0;
        end else begin
            v_out <= v_in;
            if (v_in)
                sample <= shifted[DATA_W-1:0];
        end
    end

    // R4
    r4_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_in |-> ((shifted[ACC_W-1:DATA_W-1] == '0) ||
                  (shifted[ACC_W-1:DATA_W-1] == '1)));

    // R9
    r9_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !v_in |=> ($stable(sample) && !v_out));

    // R2
    r2_out_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_in |=> v_out);

endmodule

// File: rtl/sine_lerp_interp.sv
// Module: top of the interpolating sine reader.
// Splits the phase word into index and fraction, then runs the
// read -> weight -> round pipeline. Throughput is one result per clock,
// and latency is three edges counting the capture edge.
// Assumes: synchronous active-low reset; FRAC_W >= 1.
module sine_lerp_interp #(
    parameter int IDX_W  = 10,
    parameter int FRAC_W = 3,
    parameter int DATA_W = 12,
    localparam int PH_W  = IDX_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PH_W-1:0]   in_phase,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_sample
);
    localparam int ACC_W = DATA_W + FRAC_W + 1;

    logic [IDX_W-1:0]         ph_idx;
    logic [FRAC_W-1:0]        ph_frac;
    logic                     v1;
    logic                     v2;
    logic signed [DATA_W-1:0] s_lo;
    logic signed [DATA_W-1:0] s_hi;
    logic [FRAC_W-1:0]        frac1;
    logic signed [ACC_W-1:0]  p_lo;
    logic signed [ACC_W-1:0]  p_hi;
    logic signed [DATA_W-1:0] res;

    // Phase word split: upper bits select the entry, lower bits the step.
    assign ph_idx  = in_phase[PH_W-1:FRAC_W];
    assign ph_frac = in_phase[FRAC_W-1:0];

    sine_lerp_table #(.IDX_W(IDX_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .idx      (ph_idx),
        .frac     (ph_frac),
        .rd_valid (v1),
        .samp_lo  (s_lo),
        .samp_hi  (s_hi),
        .frac_d   (frac1)
    );

    sine_lerp_weight #(.FRAC_W(FRAC_W), .DATA_W(DATA_W), .ACC_W(ACC_W)) u_weight (
        .clk     (clk),
        .rst_n   (rst_n),
        .v_in    (v1),
        .samp_lo (s_lo),
        .samp_hi (s_hi),
        .frac    (frac1),
        .v_out   (v2),
        .prod_lo (p_lo),
        .prod_hi (p_hi)
    );

    sine_lerp_sum #(.FRAC_W(FRAC_W), .DATA_W(DATA_W), .ACC_W(ACC_W)) u_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .v_in    (v2),
        .prod_lo (p_lo),
        .prod_hi (p_hi),
        .v_out   (out_valid),
        .sample  (res)
    );

    assign out_sample = res;

    // R8
    r8_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v1 && v2) |=> out_valid);

endmodule

// File: tb/sine_lerp_interp_tb.sv
`timescale 1ns/1ps
module sine_lerp_interp_tb;
    localparam int IDX_W  = 10;
    localparam int FRAC_W = 3;
    localparam int DATA_W = 12;
    localparam int PH_W   = IDX_W + FRAC_W;
    localparam int LEN    = 1 << IDX_W;
    localparam int N      = 1 << FRAC_W;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic [PH_W-1:0]   in_phase;
    logic              out_valid;
    logic [DATA_W-1:0] out_sample;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit mon_on = 0;
    logic [DATA_W-1:0] last_out = '0;

    typedef struct {
        int    val;
        int    due;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    sine_lerp_interp #(.IDX_W(IDX_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_phase   (in_phase),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R7: table entry formula.
    function automatic int tab(input int j);
        real v;
        v = real'((1 << (DATA_W - 1)) - 1) * $sin(6.283185307179586 * real'(j) / real'(LEN));
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(0.5 - v);
    endfunction

    // R4/R5: rounded weighted sum, neighbour wraps to entry 0.
    function automatic int interp(input int idx, input int k);
        int acc;
        acc = (N - k) * tab(idx) + k * tab((idx + 1) % LEN) + N / 2;
        return acc >>> FRAC_W;
    endfunction

    function automatic int sx(input logic [DATA_W-1:0] v);
        return int'($signed(v));
    endfunction

    // Driver: apply one word and push its expected result.
    task automatic drive(input int idx, input int k, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_phase = {IDX_W'(idx), FRAC_W'(k)};
        e.val = interp(idx, k);
        e.due = cyc + 3;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Idle cycles with a wandering phase that must be ignored (R9).
    task automatic idle(input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_phase = PH_W'(c * 977 + 31);
        end
    endtask

    // Monitor: pop and compare on every valid result, check hold otherwise.
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R8 unexpected output", sx(out_sample), 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(sx(out_sample) == e.val, e.tag, sx(out_sample), e.val);
                    chk(cyc == e.due, "R2 latency", cyc, e.due);
                end
            end else begin
                chk(out_sample == last_out, "R9 hold", sx(out_sample), sx(last_out));
            end
            last_out = out_sample;
        end
    end

    // Watchdog.
    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL R8 watchdog expired, %0d results pending", sb.size());
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [PH_W-1:0] lfsr;
        rst_n    = 1'b0;
        in_valid = 1'b1;
        in_phase = PH_W'(123);
        repeat (5) @(negedge clk);
        // R1
        chk(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
        chk(out_sample == '0, "R1 sample in reset", sx(out_sample), 0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
        chk(out_sample == '0, "R1 sample after reset", sx(out_sample), 0);
        mon_on = 1;

        // R3 and R7: exact table entries at k = 0
        drive(0, 0, "R3");
        drive(1, 0, "R7");
        drive(255, 0, "R7");
        drive(256, 0, "R3");
        drive(512, 0, "R7");
        drive(768, 0, "R3");
        drive(1023, 0, "R7");
        idle(4);

        // R4: every k on a rising and a falling stretch
        for (int k = 0; k < N; k++) drive(100, k, "R4");
        for (int k = 1; k < N; k++) drive(700, k, "R4");
        idle(3);

        // R5: last entry toward entry 0, all nonzero k
        for (int k = 1; k < N; k++) drive(LEN - 1, k, "R5");
        drive(LEN - 2, N - 1, "R5");
        drive(LEN - 1, N / 2, "R5");
        idle(5);

        // R6: field split
        drive(5, 3, "R6");
        drive(LEN / 2 + 3, N - 1, "R6");
        idle(2);

        // R8: long back-to-back stream
        lfsr = PH_W'(13'h1ACE);
        for (int n = 0; n < 300; n++) begin
            lfsr = {lfsr[PH_W-2:0], lfsr[PH_W-1] ^ lfsr[3] ^ lfsr[2] ^ lfsr[0]};
            drive(int'(lfsr[PH_W-1:FRAC_W]), int'(lfsr[FRAC_W-1:0]), "R8");
        end
        idle(10);

        // R9: gap with changing phase followed by one more word
        drive(300, 2, "R9");
        idle(12);

        chk(sb.size() == 0, "R8 all results delivered", sb.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule